// File: doc/BRIEF.md
# Memory-Mapped SPI Master Channel

This block is one SPI master channel controlled through a small word-addressed register bus. Software writes bytes into an eight-entry transmit queue. The shifter sends each byte MSB first on `mosi` and captures the byte arriving on `miso` at the same time. The received byte goes into an eight-entry receive queue, where software reads it back. The serial clock runs at `clk / (2 * (prescaler + 1))`. Two mode bits choose the idle level of the clock and the edge on which data is sampled.

Software drives the slave-select line directly through a register bit. A byte starts shifting only while all of these hold: select is asserted, the transmit channel is on, and the clock output is enabled. Sticky error flags record queue misuse. An interrupt-enable mask reduces the low status bits to one `irq` line. A packet limit can freeze the serial clock after a set number of completed bytes. A self-clearing soft reset flushes both queues and the shifter and keeps the configuration.

Top module: `spim_channel`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0 and `irq` is 0. The status word (offset 0x14) reads 0x0030_0001: done bit 21, trailing-zero bit 20 and TX-ready bit 0 are set. The channel config (0x00) reads 0.
- R2: Each byte is shifted MSB first.
  - Channel config bit 3 sets the idle level of `sclk`.
  - Bit 2 clear means data is sampled on the first (leading) edge of each bit. Bit 2 set means it is sampled on the second (trailing) edge.
  - The captured byte is pushed into the RX queue only when RX-on (bit 1) is set.
- R3: Clock config bits 7:0 hold the prescaler. Each half period of `sclk` lasts prescaler+1 cycles of `clk`. While clock-enable (bit 8) is clear, no byte starts.
- R4: A byte leaves the TX queue only while all of these hold:
  - slave-select register (0x0C) bit 0 is 0, which drives `ss_n` low;
  - TX-on (channel config bit 0) is set.
  Otherwise the byte stays queued.
- R5: A write to TX data (0x18) while the TX queue holds 8 entries and no byte leaves in that cycle drops the byte and sets status bit 3.
- R6: A read of RX data (0x1C) while the RX queue is empty returns 0 and sets status bit 4.
- R7: A received byte that meets a full RX queue, with no read in the same cycle, is discarded and sets status bit 5. Status bit 2 is set when a byte finishes while select is asserted and the TX queue is empty.
- R8: Writing 1s to bits 5:2 of pending-clear (0x24) clears those sticky status bits. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is the OR of status bits 5:0 masked by interrupt-enable (0x10) bits 5:0.
- R10: Packet count (0x20): bit 16 enables the limit and bits 15:0 hold it. Once the number of finished bytes reaches the limit, no further byte starts. Only a reset or soft reset clears that tally; rewriting the limit does not.
- R11: Writing 1 to channel config bit 5 has these effects:
  - it empties both queues, stops the shifter, and clears the error flags and the packet tally;
  - the configuration registers keep their values;
  - bit 5 reads back as 0.
- R12: Status bit 21 is set when the TX queue is empty and the shifter is idle. Bit 0 is set while TX level ≤ mode bits 10:5. Bit 1 is set while RX level is nonzero and ≥ mode bits 16:11.
- R13: Each accepted RX push reloads a trailing counter from mode bits 28:19. The counter then counts down once per `clk`, and status bit 20 is set while it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of operations can fall in the same cycle, and both are exercised.

The first pair is a TX-queue push by a bus write and a pop by the shifter starting the next byte. With the prescaler at 0, the bench writes eight bytes back to back while the channel is already shifting, so pushes coincide with pops.

The second pair is an RX push at the end of a byte and a bus read. The bench polls RX-ready and reads each byte as soon as it lands, so reads fall against new pushes.

In both cases the scoreboard must see every byte, both on the wire and read back, in order, and no overrun or underrun flag may appear.

// File: rtl/spim_pkg.sv
// Package: register offsets, field positions and the channel config type
// shared by the SPI master channel and its checker.
package spim_pkg;
    localparam int OFS_CHAN = 'h00;
    localparam int OFS_CLK  = 'h04;
    localparam int OFS_MODE = 'h08;
    localparam int OFS_SEL  = 'h0C;
    localparam int OFS_IEN  = 'h10;
    localparam int OFS_STAT = 'h14;
    localparam int OFS_TXD  = 'h18;
    localparam int OFS_RXD  = 'h1C;
    localparam int OFS_PKT  = 'h20;
    localparam int OFS_PCLR = 'h24;

    localparam int ST_TXDONE = 21;
    localparam int ST_TRAIL  = 20;
    localparam int ST_RXOVF  = 5;
    localparam int ST_RXUND  = 4;
    localparam int ST_TXOVF  = 3;
    localparam int ST_TXUND  = 2;
    localparam int ST_RXRDY  = 1;
    localparam int ST_TXRDY  = 0;

    localparam int CHAN_SRST_BIT = 5;
    localparam int CLK_EN_BIT    = 8;
    localparam int MODE_TXT_LSB  = 5;
    localparam int MODE_RXT_LSB  = 11;
    localparam int MODE_TRL_LSB  = 19;
    localparam int PKT_EN_BIT    = 16;

    // Channel config bits 4:0 in register order.
    typedef struct packed {
        logic slave;   // stored only; the channel is always master
        logic cpol;    // idle level of sclk
        logic cpha;    // 1: sample on the trailing edge
        logic rx_on;
        logic tx_on;
    } chan_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous FIFO with flush. Push into a full FIFO is accepted only when a
// pop happens in the same cycle. dout shows the head entry combinationally.
// Assumes DEPTH >= 2.
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign dout    = mem[rd_ptr];

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/spim_clkdiv.sv
// Edge-rate generator: while run is high, pulses tick once every presc+1
// cycles. The count restarts whenever run is low.
module spim_clkdiv #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    logic [PW-1:0] cnt;

    assign tick = run & (cnt == presc);

    // Divider count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spim_shifter.sv
// Byte shifter. On start it loads a byte and, on every tick, toggles sclk.
// Over 2*DW edges it drives mosi MSB first and samples miso. cpha selects
// whether the leading or trailing edge of each bit samples. done pulses for
// one cycle with the captured byte. abort returns it to idle at once.
module spim_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    localparam int EW = $clog2(2*DW);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW-1);

    logic [DW-1:0] tx_sh, rx_sh;
    logic [EW-1:0] edge_cnt;
    logic          sample_now;

    assign sample_now = edge_cnt[0] ^ ~cpha;   // even edge samples when cpha=0
    assign mosi       = busy & tx_sh[DW-1];

    // Bit sequencing, sclk generation and capture.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            sclk     <= rst_n ? cpol : 1'b0;
            edge_cnt <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                sclk <= cpol;
                if (start) begin
                    busy     <= 1'b1;
                    tx_sh    <= tx_byte;
                    edge_cnt <= '0;
                end
            end else if (tick) begin
                sclk     <= ~sclk;
                edge_cnt <= edge_cnt + 1'b1;
                if (sample_now) rx_sh <= {rx_sh[DW-2:0], miso};
                else if (!(cpha && edge_cnt == '0)) tx_sh <= {tx_sh[DW-2:0], 1'b0};
                if (edge_cnt == LAST_EDGE) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    rx_byte <= sample_now ? {rx_sh[DW-2:0], miso} : rx_sh;
                end
            end
        end
    end
endmodule

// File: rtl/spim_channel.sv
// SPI master channel top. It holds the register file, the TX and RX queues,
// the divider and the shifter, and the glue that starts transfers, keeps
// error flags, applies the packet limit and builds status and irq.
// Assumes: byte-addressed word registers, reads have no wait state,
// PRESC_W <= 8 and TRIG_W = 6 so the register fields do not overlap.
module spim_channel
    import spim_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int PRESC_W    = 8,
    parameter int PKT_W      = 16,
    parameter int TRAIL_W    = 10,
    parameter int TRIG_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    output logic              irq
);
    localparam int BW = 8;
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    // Register state.
    chan_cfg_t          chan_q;
    logic [PRESC_W-1:0] presc_q;
    logic               clk_en_q;
    logic [TRIG_W-1:0]  tx_trig_q, rx_trig_q;
    logic [TRAIL_W-1:0] trail_len_q, trail_cnt;
    logic               ss_q;
    logic [5:0]         inten_q;
    logic               pkt_en_q;
    logic [PKT_W-1:0]   pkt_lim_q, tally;
    logic [5:2]         err_q, err_set, err_clr;

    // Decode and datapath nets.
    logic sel_chan, sel_clk, sel_mode, sel_sel, sel_ien, sel_stat;
    logic sel_txd, sel_rxd, sel_pkt, sel_pclr;
    logic soft_rst, tx_wr, rx_rd, start_xfer, halted;
    logic tx_full, tx_empty, rx_full, rx_empty, rx_push, rx_pop;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [BW-1:0] tx_head, rx_head, sh_rx;
    logic sh_busy, sh_done, tick;
    logic [DATA_W-1:0] status, rd_d;

    assign sel_chan = (bus_addr == ADDR_W'(OFS_CHAN));
    assign sel_clk  = (bus_addr == ADDR_W'(OFS_CLK));
    assign sel_mode = (bus_addr == ADDR_W'(OFS_MODE));
    assign sel_sel  = (bus_addr == ADDR_W'(OFS_SEL));
    assign sel_ien  = (bus_addr == ADDR_W'(OFS_IEN));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign sel_txd  = (bus_addr == ADDR_W'(OFS_TXD));
    assign sel_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
    assign sel_pkt  = (bus_addr == ADDR_W'(OFS_PKT));
    assign sel_pclr = (bus_addr == ADDR_W'(OFS_PCLR));

    assign soft_rst = bus_wr & sel_chan & bus_wdata[CHAN_SRST_BIT];
    assign tx_wr    = bus_wr & sel_txd & ~soft_rst;
    assign rx_rd    = bus_rd & sel_rxd;
    assign rx_pop   = rx_rd & ~rx_empty;
    assign rx_push  = sh_done & chan_q.rx_on;

    // Limit check includes a byte finishing this cycle, so no extra start slips past.
    assign halted = pkt_en_q &&
                    (({1'b0, tally} + (PKT_W+1)'(sh_done)) >= {1'b0, pkt_lim_q});
    assign start_xfer = ~sh_busy & ~tx_empty & chan_q.tx_on & ~ss_q &
                        clk_en_q & ~halted & ~soft_rst;

    // Configuration registers; the soft reset bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q      <= '0;
            presc_q     <= '0;
            clk_en_q    <= 1'b0;
            tx_trig_q   <= '0;
            rx_trig_q   <= '0;
            trail_len_q <= '0;
            ss_q        <= 1'b1;
            inten_q     <= '0;
            pkt_en_q    <= 1'b0;
            pkt_lim_q   <= '0;
        end else if (bus_wr) begin
            if (sel_chan && !soft_rst) chan_q <= chan_cfg_t'(bus_wdata[4:0]);
            if (sel_clk) begin
                presc_q  <= bus_wdata[PRESC_W-1:0];
                clk_en_q <= bus_wdata[CLK_EN_BIT];
            end
            if (sel_mode) begin
                tx_trig_q   <= bus_wdata[MODE_TXT_LSB +: TRIG_W];
                rx_trig_q   <= bus_wdata[MODE_RXT_LSB +: TRIG_W];
                trail_len_q <= bus_wdata[MODE_TRL_LSB +: TRAIL_W];
            end
            if (sel_sel) ss_q    <= bus_wdata[0];
            if (sel_ien) inten_q <= bus_wdata[5:0];
            if (sel_pkt) begin
                pkt_en_q  <= bus_wdata[PKT_EN_BIT];
                pkt_lim_q <= bus_wdata[PKT_W-1:0];
            end
        end
    end

    // Sticky error flag sources.
    always_comb begin
        err_set[ST_TXOVF] = tx_wr & tx_full & ~start_xfer;
        err_set[ST_RXUND] = rx_rd & rx_empty;
        err_set[ST_RXOVF] = rx_push & rx_full & ~rx_pop;
        err_set[ST_TXUND] = sh_done & tx_empty & ~ss_q;
        err_clr           = (bus_wr && sel_pclr) ? bus_wdata[5:2] : '0;
    end

    // Sticky error flags: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) err_q <= '0;
        else                    err_q <= (err_q & ~err_clr) | err_set;
    end

    // Finished-byte tally for the packet limit.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) tally <= '0;
        else if (sh_done)       tally <= tally + 1'b1;
    end

    // Trailing counter: reload on each accepted RX push, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)              trail_cnt <= '0;
        else if (rx_push && (!rx_full || rx_pop)) trail_cnt <= trail_len_q;
        else if (trail_cnt != '0)            trail_cnt <= trail_cnt - 1'b1;
    end

    // Status word assembly.
    always_comb begin
        status            = '0;
        status[ST_TXDONE] = tx_empty & ~sh_busy;
        status[ST_TRAIL]  = (trail_cnt == '0);
        status[5:2]       = err_q;
        status[ST_RXRDY]  = ~rx_empty && (32'(rx_cnt) >= 32'(rx_trig_q));
        status[ST_TXRDY]  = (32'(tx_cnt) <= 32'(tx_trig_q));
    end

    assign irq  = |(status[5:0] & inten_q);
    assign ss_n = ss_q;

    // Read data multiplexer.
    always_comb begin
        rd_d = '0;
        case (bus_addr)
            ADDR_W'(OFS_CHAN): rd_d[4:0] = chan_q;
            ADDR_W'(OFS_CLK): begin
                rd_d[PRESC_W-1:0] = presc_q;
                rd_d[CLK_EN_BIT]  = clk_en_q;
            end
            ADDR_W'(OFS_MODE): begin
                rd_d[MODE_TXT_LSB +: TRIG_W]  = tx_trig_q;
                rd_d[MODE_RXT_LSB +: TRIG_W]  = rx_trig_q;
                rd_d[MODE_TRL_LSB +: TRAIL_W] = trail_len_q;
            end
            ADDR_W'(OFS_SEL):  rd_d[0]   = ss_q;
            ADDR_W'(OFS_IEN):  rd_d[5:0] = inten_q;
            ADDR_W'(OFS_STAT): rd_d      = status;
            ADDR_W'(OFS_RXD):  rd_d[BW-1:0] = rx_empty ? '0 : rx_head;
            ADDR_W'(OFS_PKT): begin
                rd_d[PKT_W-1:0]  = pkt_lim_q;
                rd_d[PKT_EN_BIT] = pkt_en_q;
            end
            default: rd_d = '0;
        endcase
    end
    assign bus_rdata = bus_rd ? rd_d : '0;

    spim_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(tx_wr), .din(bus_wdata[BW-1:0]), .pop(start_xfer),
        .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push(rx_push), .din(sh_rx), .pop(rx_pop),
        .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_clkdiv #(.PW(PRESC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(sh_busy & clk_en_q & ~soft_rst),
        .presc(presc_q), .tick(tick)
    );

    spim_shifter #(.DW(BW)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .start(start_xfer),
        .tx_byte(tx_head), .cpol(chan_q.cpol), .cpha(chan_q.cpha),
        .tick(tick), .miso(miso), .busy(sh_busy), .sclk(sclk), .mosi(mosi),
        .done(sh_done), .rx_byte(sh_rx)
    );
endmodule

// File: rtl/spim_checker.sv
// Checker for spim_channel: relates the queues, shifter, select and error
// flags over time. Attached by the bind at the end of this file.
module spim_checker
    import spim_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PKT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n,
    input logic              sclk,
    input logic              soft_rst,
    input logic              sh_busy,
    input logic              sh_done,
    input logic              clk_en,
    input logic              tx_wr,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              tx_pop,
    input logic              rx_push,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              rx_pop,
    input logic              rx_rd,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pkt_en,
    input logic [PKT_W-1:0]  tally,
    input logic [PKT_W-1:0]  lim
);
    // R2: the done pulse follows the end of a busy period.
    a_r2_done_ends_byte: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |-> $fell(sh_busy));

    // R3: with the clock output disabled, a running byte holds sclk.
    a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && !clk_en && !soft_rst) |=> $stable(sclk));

    // R4: a byte only starts while select was asserted.
    a_r4_start_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> $past(!ss_n));

    // R5: write into a full TX queue raises the TX overrun flag.
    a_r5_tx_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !tx_pop) |=> status[ST_TXOVF]);

    // R6: reading an empty RX queue returns zero and raises the flag.
    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_empty) |-> (bus_rdata == '0));
    a_r6_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_empty && !soft_rst) |=> status[ST_RXUND]);

    // R7: a byte arriving at a full RX queue raises the RX overrun flag.
    a_r7_rx_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop && !soft_rst) |=> status[ST_RXOVF]);

    // R10: no new byte once the tally has reached an enabled limit.
    a_r10_limit_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_en && tally >= lim) |=> !$rose(sh_busy));

    // R11: a soft reset leaves queues empty and the shifter idle.
    a_r11_soft_reset_flush: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_empty && rx_empty && !sh_busy));
endmodule

bind spim_channel spim_checker #(.DATA_W(DATA_W), .PKT_W(PKT_W)) i_spim_checker (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .soft_rst(soft_rst),
    .sh_busy(sh_busy), .sh_done(sh_done), .clk_en(clk_en_q),
    .tx_wr(tx_wr), .tx_full(tx_full), .tx_empty(tx_empty), .tx_pop(start_xfer),
    .rx_push(rx_push), .rx_full(rx_full), .rx_empty(rx_empty), .rx_pop(rx_pop),
    .rx_rd(rx_rd), .status(status), .bus_rdata(bus_rdata),
    .pkt_en(pkt_en_q), .tally(tally), .lim(pkt_lim_q)
);

// File: tb/test_spim_channel.sv
// Scoreboard bench: the send task queues the expected wire byte and the
// expected RX byte; a wire monitor rebuilds bytes from sclk/mosi, and the
// recv task pops and compares RX data as it is read.
module test_spim_channel;
    localparam int A_CHAN = 'h00, A_CLK = 'h04, A_MODE = 'h08, A_SEL = 'h0C;
    localparam int A_IEN = 'h10, A_STAT = 'h14, A_TXD = 'h18, A_RXD = 'h1C;
    localparam int A_PKT = 'h20, A_PCLR = 'h24;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sclk, mosi, ss_n, irq;
    logic        inv = 1'b0;
    wire         miso = inv ? ~mosi : mosi;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_wire[$], exp_rx[$];
    bit b_cpol = 0, b_cpha = 0;
    int n_ser = 0, last_gap = 0;

    always #4 clk = ~clk;

    spim_channel i_spim_channel (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = 6'(a); bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit on_wire, input bit keep_rx);
        bus_write(A_TXD, {24'h0, b});
        if (on_wire) exp_wire.push_back(b);
        if (keep_rx) exp_rx.push_back(inv ? ~b : b);
    endtask

    task automatic recv(input string req);
        logic [31:0] d;
        bus_read(A_RXD, d);
        if (exp_rx.size() == 0) check(req, d, 32'hxxxx_xxxx);
        else check(req, d, {24'h0, exp_rx.pop_front()});
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(A_STAT, s);
            if (s[21]) break;
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic stat_bit(input string req, input int bitpos, input logic exp);
        logic [31:0] s;
        bus_read(A_STAT, s);
        check(req, {31'h0, s[bitpos]}, {31'h0, exp});
    endtask

    // Wire monitor: rebuild bytes on the sampling edges and compare.
    int cyc = 0, nb = 0, ec = 0, last_edge = 0;
    logic prev_sclk = 1'b0;
    logic [7:0] wsh = '0;
    always @(negedge clk) begin
        cyc++;
        if (ss_n !== 1'b0) begin
            nb = 0; ec = 0;
        end else if (sclk !== prev_sclk) begin
            if (ec > 0) last_gap = cyc - last_edge;
            last_edge = cyc;
            ec++;
            if ((sclk != b_cpol) ^ b_cpha) begin
                wsh = {wsh[6:0], mosi};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    n_ser++;
                    if (exp_wire.size() == 0) check("R2 wire byte", {24'h0, wsh}, 32'hxxxx_xxxx);
                    else check("R2 wire byte", {24'h0, wsh}, {24'h0, exp_wire.pop_front()});
                end
            end
            if (ec == 16) ec = 0;
        end
        prev_sclk = sclk;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int snap;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ss_n", {31'h0, ss_n}, 32'h1);
        check("R1 sclk", {31'h0, sclk}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        bus_read(A_STAT, d); check("R1 status", d, 32'h0030_0001);
        bus_read(A_CHAN, d); check("R1 chan", d, 32'h0);

        // R2/R3 loopback in each of the four modes, with half-period timing
        for (int m = 0; m < 4; m++) begin
            b_cpol = m[1]; b_cpha = m[0]; inv = (m == 3);
            bus_write(A_SEL, 1);
            bus_write(A_CHAN, 32'h3 | (m[1] << 3) | (m[0] << 2));
            bus_write(A_CLK, 32'h100 | (m + 1));
            repeat (2) @(posedge clk); @(negedge clk);
            check("R2 idle level", {31'h0, sclk}, {31'h0, b_cpol});
            bus_write(A_SEL, 0);
            send(8'hA5 ^ 8'(m * 17), 1, 1);
            send(8'h3C, 1, 1);
            wait_idle();
            recv("R2 rx byte");
            recv("R2 rx byte");
            check("R3 half period", last_gap, m + 2);
            bus_write(A_SEL, 1);
        end
        inv = 1'b0; b_cpol = 0; b_cpha = 0;
        bus_write(A_CHAN, 32'h3);
        bus_write(A_PCLR, 32'h3C);

        // R4 select deasserted / TX off hold the byte
        snap = n_ser;
        send(8'h5A, 1, 1);
        repeat (60) @(posedge clk);
        check("R4 no start while deselected", n_ser, snap);
        stat_bit("R4 queued byte pending", 21, 1'b0);
        bus_write(A_CHAN, 32'h2);
        bus_write(A_SEL, 0);
        repeat (60) @(posedge clk);
        check("R4 no start with tx off", n_ser, snap);
        bus_write(A_CHAN, 32'h3);
        wait_idle();
        recv("R4 byte after enabling");

        // R3 clock output disabled holds the byte
        bus_write(A_CLK, 32'h001);
        snap = n_ser;
        send(8'hC3, 1, 1);
        repeat (60) @(posedge clk);
        check("R3 no start without clock enable", n_ser, snap);
        bus_write(A_CLK, 32'h101);
        wait_idle();
        recv("R3 byte after clock enable");

        // R2 RX channel off: byte is sent but not stored
        bus_write(A_CHAN, 32'h1);
        send(8'h99, 1, 0);
        wait_idle();
        bus_read(A_RXD, d); check("R2 rx off leaves queue empty", d, 32'h0);
        bus_write(A_CHAN, 32'h3);
        bus_write(A_PCLR, 32'h3C);

        // R12 RX ready level and TX ready level
        bus_write(A_MODE, 32'h2 << 11);
        send(8'h11, 1, 1);
        wait_idle();
        stat_bit("R12 rx below trigger", 1, 1'b0);
        send(8'h22, 1, 1);
        wait_idle();
        stat_bit("R12 rx at trigger", 1, 1'b1);
        recv("R12 rx"); recv("R12 rx");
        bus_write(A_MODE, 32'h0);
        bus_write(A_SEL, 1);
        send(8'h44, 1, 1);
        stat_bit("R12 tx above trigger", 0, 1'b0);
        bus_write(A_MODE, 32'h1 << 5);
        stat_bit("R12 tx at trigger", 0, 1'b1);
        bus_write(A_MODE, 32'h0);

        // R5 overflow of TX queue (one already queued)
        for (int i = 1; i < 8; i++) send(8'(8'h50 + i), 1, 1);
        stat_bit("R5 no overrun at eight", 3, 1'b0);
        send(8'hEE, 0, 0);
        stat_bit("R5 overrun flag", 3, 1'b1);
        bus_write(A_SEL, 0);
        wait_idle();
        // R7 RX overrun: queue holds eight, ninth is dropped
        send(8'h77, 1, 0);
        wait_idle();
        stat_bit("R7 rx overrun flag", 5, 1'b1);
        stat_bit("R7 tx underrun flag", 2, 1'b1);
        for (int i = 0; i < 8; i++) recv("R5 queued bytes intact");
        // R6 empty read
        bus_read(A_RXD, d); check("R6 empty read value", d, 32'h0);
        stat_bit("R6 underrun flag", 4, 1'b1);

        // R9 interrupt masking
        check("R9 masked irq", {31'h0, irq}, 32'h0);
        bus_write(A_IEN, 32'h10);
        @(negedge clk); check("R9 enabled irq", {31'h0, irq}, 32'h1);
        // R8 pending clear of a single flag
        bus_write(A_PCLR, 32'h10);
        bus_read(A_STAT, d); check("R8 selective clear", {26'h0, d[5:0]}, 32'h2D);
        @(negedge clk); check("R9 irq after clear", {31'h0, irq}, 32'h0);
        bus_write(A_PCLR, 32'h3C);
        bus_read(A_STAT, d); check("R8 full clear", {26'h0, d[5:2], 2'b0}, 32'h0);
        bus_write(A_IEN, 32'h0);

        // R13 trailing counter
        bus_write(A_MODE, 32'd1000 << 19);
        bus_write(A_CLK, 32'h100);
        send(8'h6B, 1, 1);
        wait_idle();
        stat_bit("R13 trailing running", 20, 1'b0);
        repeat (1100) @(posedge clk);
        stat_bit("R13 trailing expired", 20, 1'b1);
        recv("R13 rx");
        bus_write(A_MODE, 32'h0);

        // R10 packet limit and R11 soft reset
        bus_write(A_CHAN, 32'h23);
        bus_write(A_PKT, 32'h1_0002);
        snap = n_ser;
        send(8'h81, 1, 1); send(8'h82, 1, 1); send(8'h83, 0, 0);
        repeat (200) @(posedge clk);
        check("R10 stops at limit", n_ser, snap + 2);
        stat_bit("R10 third byte held", 21, 1'b0);
        recv("R10 rx"); recv("R10 rx");
        bus_write(A_PKT, 32'h1_0002);
        repeat (100) @(posedge clk);
        check("R10 rewrite does not rearm", n_ser, snap + 2);
        bus_write(A_SEL, 1);
        send(8'h84, 0, 0);
        bus_write(A_CHAN, 32'h23);
        bus_read(A_CHAN, d); check("R11 config kept", d, 32'h3);
        bus_read(A_CLK, d); check("R11 clock config kept", d, 32'h100);
        bus_read(A_PKT, d); check("R11 packet config kept", d, 32'h1_0002);
        bus_read(A_STAT, d); check("R11 flushed status", d, 32'h0030_0001);
        bus_write(A_SEL, 0);
        send(8'h85, 1, 1);
        wait_idle();
        recv("R10 rearmed after soft reset");
        bus_write(A_PKT, 32'h0);

        // Same-cycle push/pop on both queues
        bus_write(A_PCLR, 32'h3C);
        bus_write(A_IEN, 32'h38);
        for (int i = 0; i < 8; i++) send(8'(8'hB0 + 3 * i), 1, 1);
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 400; k++) begin
                bus_read(A_STAT, d);
                if (d[1]) break;
            end
            recv("R12 back-to-back rx");
        end
        check("R9 no overrun/underrun irq", {31'h0, irq}, 32'h0);
        check("R2 all wire bytes seen", exp_wire.size(), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule